// File: doc/BRIEF.md
# Character LCD Nibble Write Engine

This block takes bytes from a host over a valid/ready handshake and writes them to a character LCD through a write-only 4-bit parallel bus. The bus has a register-select line, a read/write line held low, an enable strobe and four data lines. Each accepted byte goes out as two nibbles, upper half first. Each nibble gets its own enable pulse, and the block enforces a setup time before the strobe, a minimum strobe width and a hold time after it.

After the last strobe of a request, the block stays busy for the display's execution time. The controller's clear and return-home commands are much slower than every other operation. The block recognises them from the command byte and picks the long wait for them. A single-nibble request is also provided for the power-up sequence, before the display is in 4-bit mode. That request sends only the upper nibble, and the host supplies its wait in clock cycles. All timing is given in nanoseconds or microseconds and converted to whole clock cycles, rounded up, from the clock frequency parameter.

Top module: `lcd_nibble_writer`

## Requirements
- R1: A request is taken on a rising edge where `req_valid` and `req_ready` are both high, and `req_ready` is low from the next cycle until the request's wait has fully elapsed.
- R2: `lcd_e` is low at reset and whenever `req_ready` is high.
- R3: Each enable pulse stays high for exactly ceil(E_HIGH_NS·CLK_HZ/1e9) cycles, with a minimum of 1.
- R4: `lcd_rs` and the nibble are driven for ceil(SETUP_NS·CLK_HZ/1e9) cycles before `lcd_e` rises. They stay unchanged while `lcd_e` is high and for ceil(HOLD_NS·CLK_HZ/1e9) cycles after it falls.
- R5: A full byte gives exactly two enable pulses. Bits [7:4] are on `lcd_d` when the first pulse falls, and bits [3:0] when the second falls.
- R6: A command (`req_rs`=0) whose bits [7:2] are all zero gets the long wait. The total busy time is 2·(setup+high+hold) plus ceil(LONG_US·CLK_HZ/1e6) cycles.
- R7: Any other command gets the short wait of ceil(SHORT_US·CLK_HZ/1e6) cycles after the second pulse's hold.
- R8: A data write (`req_rs`=1) always gets the short wait, whatever the byte value.
- R9: A request with `req_single`=1 gives one enable pulse carrying bits [7:4]. It is followed by a wait of `req_wait` cycles, at least 1, so the busy time is setup+high+hold+max(`req_wait`,1).
- R10: `lcd_rw` is low in every cycle.
- R11: During reset, `req_ready` is high and `lcd_e`, `lcd_rs` and `lcd_d` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_rs | input | 1 | 0 = command, 1 = data |
| req_byte | input | 8 | Byte to write |
| req_single | input | 1 | Send upper nibble only |
| req_wait | input | WAIT_W | Wait cycles after a single-nibble request |
| lcd_rs | output | 1 | Display register select |
| lcd_rw | output | 1 | Display read/write, always write |
| lcd_e | output | 1 | Display enable strobe |
| lcd_d | output | 4 | Display data nibble |

## Verification
The assertions check the strobe rules on every cycle: the enable is low while idle, the exact high width of each pulse, and that register select and data are stable across each pulse and at its falling edge. They also check that an accepted request drops `req_ready` and that the phase counter counts down. The bench scenarios are the only place where the decoded wait length is shown. They measure, per command class, per data write and per single-nibble request, which nibble was present at each falling edge and how many pulses went out. They also measure the exact setup and hold gaps, including the boundary between bytes 0x03 and 0x04.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_EHIGH,
        PH_HOLD,
        PH_WAIT
    } phase_e;

    // Cycles covering a span of ns at hz, rounded up, never below one.
    function automatic longint unsigned ns_to_cyc(longint unsigned ns, longint unsigned hz);
        longint unsigned c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        return (c == 0) ? 64'd1 : c;
    endfunction

    function automatic longint unsigned max3(longint unsigned a, longint unsigned b,
                                             longint unsigned c);
        longint unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/lcdw_timer.sv
module lcdw_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R4: phase lengths depend on a steady one-per-cycle countdown
    a_r4_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/lcdw_wait_sel.sv
module lcdw_wait_sel #(
    parameter int          CNT_W    = 16,
    parameter int          WAIT_W   = 12,
    parameter logic [CNT_W-1:0] SHORT_M1 = '0,
    parameter logic [CNT_W-1:0] LONG_M1  = '0
) (
    input  logic              rs,
    input  logic [7:2]        cmd_top,
    input  logic              single,
    input  logic [WAIT_W-1:0] host_wait,
    output logic [CNT_W-1:0]  wait_m1
);
    logic slow_cmd;

    // Clear and return-home are the only commands with bits [7:2] all zero.
    assign slow_cmd = !rs && (cmd_top == 6'd0);

    always_comb begin
        if (single)
            wait_m1 = (host_wait == '0) ? '0 : CNT_W'(host_wait - 1'b1);
        else if (slow_cmd)
            wait_m1 = LONG_M1;
        else
            wait_m1 = SHORT_M1;
    end

endmodule

// File: rtl/lcd_nibble_writer.sv
module lcd_nibble_writer #(
    parameter int unsigned CLK_HZ    = 50_000_000,
    parameter int unsigned E_HIGH_NS = 300,
    parameter int unsigned SETUP_NS  = 60,
    parameter int unsigned HOLD_NS   = 20,
    parameter int unsigned SHORT_US  = 50,
    parameter int unsigned LONG_US   = 2050,
    parameter int          WAIT_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_rs,
    input  logic [7:0]        req_byte,
    input  logic              req_single,
    input  logic [WAIT_W-1:0] req_wait,
    output logic              lcd_rs,
    output logic              lcd_rw,
    output logic              lcd_e,
    output logic [3:0]        lcd_d
);
    import lcdw_pkg::*;

    localparam longint unsigned EHI_CYC   = ns_to_cyc(64'(E_HIGH_NS), 64'(CLK_HZ));
    localparam longint unsigned SETUP_CYC = ns_to_cyc(64'(SETUP_NS), 64'(CLK_HZ));
    localparam longint unsigned HOLD_CYC  = ns_to_cyc(64'(HOLD_NS), 64'(CLK_HZ));
    localparam longint unsigned SHORT_CYC = ns_to_cyc(64'(SHORT_US) * 64'd1000, 64'(CLK_HZ));
    localparam longint unsigned LONG_CYC  = ns_to_cyc(64'(LONG_US) * 64'd1000, 64'(CLK_HZ));
    localparam longint unsigned MAX_CYC   = max3(max3(EHI_CYC, SETUP_CYC, HOLD_CYC),
                                                 SHORT_CYC, LONG_CYC);
    localparam int CYC_W = $clog2(MAX_CYC + 1);
    localparam int CNT_W = (CYC_W > WAIT_W) ? CYC_W : WAIT_W;

    localparam logic [CNT_W-1:0] EHI_M1   = CNT_W'(EHI_CYC - 1);
    localparam logic [CNT_W-1:0] SETUP_M1 = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_M1  = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] SHORT_M1 = CNT_W'(SHORT_CYC - 1);
    localparam logic [CNT_W-1:0] LONG_M1  = CNT_W'(LONG_CYC - 1);

    typedef struct packed {
        phase_e           ph;
        logic             lo_half;
        logic             single;
        logic             rs;
        logic [3:0]       lo_nib;
        logic             e;
        logic [3:0]       d;
        logic [CNT_W-1:0] wait_m1;
    } eng_s;

    eng_s             s_d, s_q;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_done;
    logic [CNT_W-1:0] sel_wait_m1;

    lcdw_wait_sel #(
        .CNT_W   (CNT_W),
        .WAIT_W  (WAIT_W),
        .SHORT_M1(SHORT_M1),
        .LONG_M1 (LONG_M1)
    ) u_wait_sel (
        .rs       (req_rs),
        .cmd_top  (req_byte[7:2]),
        .single   (req_single),
        .host_wait(req_wait),
        .wait_m1  (sel_wait_m1)
    );

    lcdw_timer #(.W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .load_val(t_val),
        .expired (t_done)
    );

    always_comb begin
        s_d    = s_q;
        t_load = 1'b0;
        t_val  = '0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.ph      = PH_SETUP;
                    s_d.rs      = req_rs;
                    s_d.single  = req_single;
                    s_d.lo_half = 1'b0;
                    s_d.d       = req_byte[7:4];
                    s_d.lo_nib  = req_byte[3:0];
                    s_d.wait_m1 = sel_wait_m1;
                    t_load      = 1'b1;
                    t_val       = SETUP_M1;
                end
            end
            PH_SETUP: begin
                if (t_done) begin
                    s_d.ph = PH_EHIGH;
                    s_d.e  = 1'b1;
                    t_load = 1'b1;
                    t_val  = EHI_M1;
                end
            end
            PH_EHIGH: begin
                if (t_done) begin
                    s_d.ph = PH_HOLD;
                    s_d.e  = 1'b0;
                    t_load = 1'b1;
                    t_val  = HOLD_M1;
                end
            end
            PH_HOLD: begin
                if (t_done) begin
                    t_load = 1'b1;
                    if (!s_q.lo_half && !s_q.single) begin
                        s_d.ph      = PH_SETUP;
                        s_d.lo_half = 1'b1;
                        s_d.d       = s_q.lo_nib;
                        t_val       = SETUP_M1;
                    end else begin
                        s_d.ph = PH_WAIT;
                        t_val  = s_q.wait_m1;
                    end
                end
            end
            PH_WAIT: begin
                if (t_done) s_d.ph = PH_IDLE;
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: PH_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign req_ready = (s_q.ph == PH_IDLE);
    assign lcd_rs    = s_q.rs;
    assign lcd_rw    = 1'b0;
    assign lcd_e     = s_q.e;
    assign lcd_d     = s_q.d;

    // Checker state: length of the current enable pulse.
    logic [CNT_W-1:0] e_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     e_run_q <= '0;
        else if (lcd_e) e_run_q <= e_run_q + 1'b1;
        else            e_run_q <= '0;
    end

    a_r1_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r2_e_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !lcd_e);

    a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_e) |-> (e_run_q == CNT_W'(EHI_CYC)));

    a_r4_rs_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_e) |-> $stable(lcd_rs) && $stable(lcd_d));

    a_r4_bus_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && $past(lcd_e)) |-> ($stable(lcd_d) && $stable(lcd_rs)));

    a_r4_data_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_e) |-> $stable(lcd_d));

endmodule

// File: tb/lcd_nibble_writer_bench.sv
module lcd_nibble_writer_bench;
    localparam int S   = 5;    // ceil(45 ns at 100 MHz)
    localparam int H   = 26;   // ceil(255 ns)
    localparam int HO  = 2;    // ceil(15 ns)
    localparam int SW  = 500;  // 5 us
    localparam int LW  = 2000; // 20 us
    localparam int WW  = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_rs = 1'b0;
    logic [7:0]    req_byte = '0;
    logic          req_single = 1'b0;
    logic [WW-1:0] req_wait = '0;
    logic          lcd_rs, lcd_rw, lcd_e;
    logic [3:0]    lcd_d;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    lcd_nibble_writer #(
        .CLK_HZ(100_000_000), .E_HIGH_NS(255), .SETUP_NS(45), .HOLD_NS(15),
        .SHORT_US(5), .LONG_US(20), .WAIT_W(WW)
    ) u_lcd_nibble_writer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_rs(req_rs), .req_byte(req_byte), .req_single(req_single),
        .req_wait(req_wait), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e),
        .lcd_d(lcd_d)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send(input string req, input logic rs, input logic [7:0] b,
                        input logic single, input logic [WW-1:0] wt, input int exp_wait);
        int busy = 0, falls = 0, run = 0, bad_run = 0, setup = -1, gap = 0;
        int rs_err = 0, rw_err = 0, first_ready = -1;
        logic [3:0] nib0 = '0, nib1 = '0, last_d = '0;
        logic prev_e = 1'b0;
        int n_pulse = single ? 1 : 2;
        @(negedge clk);
        req_valid = 1'b1; req_rs = rs; req_byte = b; req_single = single; req_wait = wt;
        @(negedge clk);
        req_valid = 1'b0; req_byte = ~b; req_rs = ~rs;
        for (int i = 0; i < 5000; i++) begin
            if (first_ready < 0) first_ready = int'(req_ready);
            if (lcd_rw !== 1'b0) rw_err++;
            if (lcd_e) begin
                if (!prev_e && falls == 0) setup = busy;
                run++;
                last_d = lcd_d;
                if (lcd_rs !== rs) rs_err++;
            end else if (prev_e) begin
                if (run != H) bad_run++;
                if (lcd_d !== last_d) rs_err++;
                if (falls == 0) nib0 = last_d; else nib1 = last_d;
                run = 0;
                falls++;
            end
            if (!lcd_e && falls == 1 && !single) gap++;
            if (req_ready) break;
            busy++;
            prev_e = lcd_e;
            @(negedge clk);
        end
        check("R1", {req, " ready low after accept"}, first_ready, 0);
        check(single ? "R9" : (exp_wait == LW ? "R6" : (rs ? "R8" : "R7")),
              {req, " busy cycles"}, busy, n_pulse * (S + H + HO) + exp_wait);
        check(single ? "R9" : "R5", {req, " pulse count"}, falls, n_pulse);
        check("R3", {req, " pulses of wrong width"}, bad_run, 0);
        check("R4", {req, " setup before first rise"}, setup, S);
        check("R4", {req, " rs/data moved around strobe"}, rs_err, 0);
        check("R10", {req, " rw high"}, rw_err, 0);
        check(single ? "R9" : "R5", {req, " first nibble"}, int'(nib0), int'(b[7:4]));
        if (!single) begin
            check("R5", {req, " second nibble"}, int'(nib1), int'(b[3:0]));
            check("R4", {req, " hold+setup gap"}, gap, HO + S);
        end
        check("R2", {req, " e low when idle"}, int'(lcd_e), 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R11", "ready in reset", int'(req_ready), 1);
        check("R11", "e in reset", int'(lcd_e), 0);
        check("R11", "rs in reset", int'(lcd_rs), 0);
        check("R11", "d in reset", int'(lcd_d), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", "e low idle after reset", int'(lcd_e), 0);
    endtask

    task automatic t_slow_cmds;
        send("clear 0x01", 1'b0, 8'h01, 1'b0, '0, LW);
        send("home 0x02", 1'b0, 8'h02, 1'b0, '0, LW);
        send("edge 0x03", 1'b0, 8'h03, 1'b0, '0, LW);
    endtask

    task automatic t_fast_cmds;
        send("entry 0x04", 1'b0, 8'h04, 1'b0, '0, SW);
        send("cmd 0xA5", 1'b0, 8'hA5, 1'b0, '0, SW);
        send("cmd 0x80", 1'b0, 8'h80, 1'b0, '0, SW);
    endtask

    task automatic t_data;
        send("data 0x01", 1'b1, 8'h01, 1'b0, '0, SW);
        send("data 0x5C", 1'b1, 8'h5C, 1'b0, '0, SW);
    endtask

    task automatic t_single;
        send("nibble 0x3x", 1'b0, 8'h3F, 1'b1, 12'd40, 40);
        send("nibble 0x2x wait0", 1'b0, 8'h20, 1'b1, 12'd0, 1);
        send("nibble 0x0x", 1'b0, 8'h01, 1'b1, 12'd7, 7);
    endtask

    initial begin
        t_reset();
        t_slow_cmds();
        t_fast_cmds();
        t_data();
        t_single();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200_000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule